// File: doc/BRIEF.md
# Clock Output Gate with Power-Down Control

This block decides, for each of fourteen clock outputs, whether the output passes its source clock, sits at a fixed idle level, or floats. It combines four inputs: a chip-wide power-good level, four pin-level enables, an eight-bit lane-enable field and an eight-bit miscellaneous control field. The outputs come in three groups. Two are differential pairs: a CPU clock and a 96 MHz clock. Eight are single-ended Ethernet reference lanes. Four are single-ended slow clocks: one at 32.768 kHz, two at 25 MHz and one at 33.33 MHz.

Each output has its own gating cell that runs in the domain of its own source clock. Every run request passes through a resynchroniser and is applied on a falling edge of the source. As a result, an output only starts or stops between complete high phases. Dropping power-good stops every output at once. Raising power-good again lets each output resume in step with its own clock.

The pad drive and the generation of the source clocks sit outside the block. Single-ended outputs are always driven. Differential outputs have an output-enable that the pad ring uses to float them.

Top module: `clk_out_gate`

## Requirements
- R1: While `pwr_good` is 0, every true and single-ended output is 0. The stop takes effect as soon as `pwr_good` falls, without waiting for any source edge.
- R2: After `pwr_good` rises, each output keeps its power-down state through the first two rising edges of its own source, then follows its run request from the third rising edge.
- R3: The 96 MHz pair (`dot_t`) runs only when `pwr_good`, `pin_en_dot` and `ctl_misc[0]` are all 1.
- R4: The CPU pair (`cpu_t`) runs only when `pwr_good`, `pin_en_cpu` and `ctl_misc[1]` are all 1.
- R5: With `pwr_good` settled high, a differential pair that is not running has its output-enable at 0 (floating), and a running pair has it at 1. The complement output is always the inverse of the true output.
- R6: In power-down, `cpu_oe` equals the inverse of `ctl_misc[7]` and `dot_oe` equals the inverse of `ctl_misc[6]`. A value of 1 floats the pair. A value of 0 drives it with true low and complement high.
- R7: Lane k (`se_q[k]`, k = 0..7) runs when `ctl_lane_en[k]` is 1 and its group pin is 1. The group pin is `pin_en_lo` for lanes 0..3 and `pin_en_hi` for lanes 4..7. A lane that is not running is held at 0.
- R8: `se_q[8]`, `se_q[9]`, `se_q[10]` and `se_q[11]` (32.768 kHz, 25 MHz #0, 25 MHz #1, 33.33 MHz) are enabled by `ctl_misc` bits 2, 3, 4 and 5 respectively. A disabled output is held at 0, and all `se_oe` bits are always 1.
- R9: After any change to an enable, an output keeps its previous behaviour through two rising edges of its source and takes on the new behaviour from the third. It produces only complete high phases.
- R10: No true or single-ended output is ever 1 while its source clock is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pwr_good | input | 1 | Power good; 0 forces power-down |
| pin_en_cpu | input | 1 | Pin enable of the CPU pair |
| pin_en_dot | input | 1 | Pin enable of the 96 MHz pair |
| pin_en_lo | input | 1 | Group pin enable for lanes 0..3 |
| pin_en_hi | input | 1 | Group pin enable for lanes 4..7 |
| ctl_lane_en | input | LANES | Per-lane enable bits |
| ctl_misc | input | 8 | Pair enables, slow-clock enables, power-down float selects |
| src_cpu | input | 1 | Source clock of the CPU pair |
| src_dot | input | 1 | Source clock of the 96 MHz pair |
| se_src | input | LANES+4 | Source clocks of the single-ended outputs |
| cpu_t | output | 1 | CPU pair true output |
| cpu_c | output | 1 | CPU pair complement output |
| cpu_oe | output | 1 | CPU pair output-enable |
| dot_t | output | 1 | 96 MHz pair true output |
| dot_c | output | 1 | 96 MHz pair complement output |
| dot_oe | output | 1 | 96 MHz pair output-enable |
| se_q | output | LANES+4 | Gated single-ended outputs |
| se_oe | output | LANES+4 | Single-ended output-enables |

## Verification
On every source edge, the assertions check three things. First, power-down forces the CPU pair, the 96 MHz pair and lane 0 low. Second, the power-down output-enable follows the float-select bits. Third, no gated output is ever high while its source is low. They also check that a CPU pair whose pin and control bits have been steady for four edges is running or floating as required. The bench scenarios show what the assertions cannot. A near-exhaustive sweep covers all pin-enable patterns against many control patterns for every output. Timed probes check the exact edge on which an output starts or stops after an enable change and after power-good returns.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

  // Width of the miscellaneous control field.
  localparam int CTL_W = 8;

  // Bit positions inside ctl_misc; the gating decodes them directly.
  localparam int MB_DOT_EN  = 0;
  localparam int MB_CPU_EN  = 1;
  localparam int MB_SLOW_EN = 2;
  localparam int MB_REF0_EN = 3;
  localparam int MB_REF1_EN = 4;
  localparam int MB_MID_EN  = 5;
  localparam int MB_DOT_HIZ = 6;
  localparam int MB_CPU_HIZ = 7;

  // Offsets of the slow clocks above the lanes in se_q.
  localparam int SE_SLOW = 0;
  localparam int SE_REF0 = 1;
  localparam int SE_REF1 = 2;
  localparam int SE_MID  = 3;
  localparam int SE_EXTRA = 4;

  // What an output does when powered but not running.
  typedef enum logic {
    OFF_DRIVE_LOW = 1'b0,
    OFF_FLOAT     = 1'b1
  } off_mode_e;

endpackage

// File: rtl/cg_sync.sv
module cg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/cg_cell.sv
module cg_cell
  import clkgate_pkg::*;
#(
  parameter off_mode_e OFF_MODE    = OFF_DRIVE_LOW,
  parameter int        SYNC_STAGES = 2
) (
  input  logic src,
  input  logic pwr_good,
  input  logic run_req,
  input  logic pd_float,
  output logic q,
  output logic oe
);

  logic live_s, run_s;
  logic live_g, run_g;

  // Power-good and run request, brought into the source domain.
  cg_sync #(.STAGES(SYNC_STAGES)) u_live (
    .clk(src), .clr_n(pwr_good), .d(1'b1), .q(live_s)
  );
  cg_sync #(.STAGES(SYNC_STAGES)) u_run (
    .clk(src), .clr_n(pwr_good), .d(run_req), .q(run_s)
  );

  // Applied on the falling edge so the gate only moves while src is low.
  always_ff @(negedge src or negedge pwr_good) begin
    if (!pwr_good) begin
      live_g <= 1'b0;
      run_g  <= 1'b0;
    end else begin
      live_g <= live_s;
      run_g  <= run_s & live_s;
    end
  end

  assign q = src & run_g;

  always_comb begin
    if (!live_g)                 oe = ~pd_float;
    else if (OFF_MODE == OFF_FLOAT) oe = run_g;
    else                         oe = 1'b1;
  end

endmodule

// File: rtl/clk_out_gate.sv
module clk_out_gate
  import clkgate_pkg::*;
#(
  parameter int LANES       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int SE_N       = LANES + SE_EXTRA,
  localparam int HALF       = LANES / 2
) (
  input  logic             pwr_good,
  input  logic             pin_en_cpu,
  input  logic             pin_en_dot,
  input  logic             pin_en_lo,
  input  logic             pin_en_hi,
  input  logic [LANES-1:0] ctl_lane_en,
  input  logic [CTL_W-1:0] ctl_misc,
  input  logic             src_cpu,
  input  logic             src_dot,
  input  logic [SE_N-1:0]  se_src,
  output logic             cpu_t,
  output logic             cpu_c,
  output logic             cpu_oe,
  output logic             dot_t,
  output logic             dot_c,
  output logic             dot_oe,
  output logic [SE_N-1:0]  se_q,
  output logic [SE_N-1:0]  se_oe
);

  logic [SE_N-1:0] se_req;
  logic cpu_q, dot_q;

  // Lane requests: own bit and the group pin of its half.
  for (genvar i = 0; i < LANES; i++) begin : g_lane_req
    if (i < HALF) begin : g_lo
      assign se_req[i] = ctl_lane_en[i] & pin_en_lo;
    end else begin : g_hi
      assign se_req[i] = ctl_lane_en[i] & pin_en_hi;
    end
  end

  assign se_req[LANES+SE_SLOW] = ctl_misc[MB_SLOW_EN];
  assign se_req[LANES+SE_REF0] = ctl_misc[MB_REF0_EN];
  assign se_req[LANES+SE_REF1] = ctl_misc[MB_REF1_EN];
  assign se_req[LANES+SE_MID]  = ctl_misc[MB_MID_EN];

  for (genvar i = 0; i < SE_N; i++) begin : g_se
    cg_cell #(.OFF_MODE(OFF_DRIVE_LOW), .SYNC_STAGES(SYNC_STAGES)) u_cell (
      .src      (se_src[i]),
      .pwr_good (pwr_good),
      .run_req  (se_req[i]),
      .pd_float (1'b0),
      .q        (se_q[i]),
      .oe       (se_oe[i])
    );
  end

  cg_cell #(.OFF_MODE(OFF_FLOAT), .SYNC_STAGES(SYNC_STAGES)) u_cpu (
    .src      (src_cpu),
    .pwr_good (pwr_good),
    .run_req  (pin_en_cpu & ctl_misc[MB_CPU_EN]),
    .pd_float (ctl_misc[MB_CPU_HIZ]),
    .q        (cpu_q),
    .oe       (cpu_oe)
  );

  cg_cell #(.OFF_MODE(OFF_FLOAT), .SYNC_STAGES(SYNC_STAGES)) u_dot (
    .src      (src_dot),
    .pwr_good (pwr_good),
    .run_req  (pin_en_dot & ctl_misc[MB_DOT_EN]),
    .pd_float (ctl_misc[MB_DOT_HIZ]),
    .q        (dot_q),
    .oe       (dot_oe)
  );

  assign cpu_t = cpu_q;
  assign cpu_c = ~cpu_q;
  assign dot_t = dot_q;
  assign dot_c = ~dot_q;

endmodule

// File: rtl/clk_out_gate_chk.sv
module clk_out_gate_chk (
  input logic pwr_good,
  input logic pin_en_cpu,
  input logic cpu_en_bit,
  input logic cpu_hiz_bit,
  input logic dot_hiz_bit,
  input logic src_cpu,
  input logic cpu_t,
  input logic cpu_oe,
  input logic src_dot,
  input logic dot_t,
  input logic dot_oe,
  input logic lane0_src,
  input logic lane0_q
);

  // R1
  pd_cpu_low_chk: assert property (@(negedge src_cpu) !pwr_good |-> !cpu_t);
  // R1
  pd_dot_low_chk: assert property (@(negedge src_dot) !pwr_good |-> !dot_t);
  // R1
  pd_lane_low_chk: assert property (@(negedge lane0_src) !pwr_good |-> !lane0_q);
  // R6
  pd_cpu_oe_chk: assert property (@(negedge src_cpu) !pwr_good |-> (cpu_oe == !cpu_hiz_bit));
  // R6
  pd_dot_oe_chk: assert property (@(negedge src_dot) !pwr_good |-> (dot_oe == !dot_hiz_bit));
  // R10
  cpu_src_low_chk: assert property (@(posedge src_cpu) disable iff (!pwr_good) !cpu_t);
  // R10
  lane_src_low_chk: assert property (@(posedge lane0_src) disable iff (!pwr_good) !lane0_q);
  // R5
  cpu_float_chk: assert property (@(negedge src_cpu) disable iff (!pwr_good)
    ($past(pwr_good, 3) && $past(pwr_good, 2) && $past(pwr_good) &&
     !pin_en_cpu && !$past(pin_en_cpu) && !$past(pin_en_cpu, 2) && !$past(pin_en_cpu, 3))
    |-> (!cpu_oe && !cpu_t));
  // R4
  cpu_run_chk: assert property (@(negedge src_cpu) disable iff (!pwr_good)
    ($past(pwr_good, 3) && $past(pwr_good, 2) && $past(pwr_good) &&
     pin_en_cpu && $past(pin_en_cpu) && $past(pin_en_cpu, 2) && $past(pin_en_cpu, 3) &&
     cpu_en_bit && $past(cpu_en_bit) && $past(cpu_en_bit, 2) && $past(cpu_en_bit, 3))
    |-> (cpu_oe && cpu_t));

endmodule

bind clk_out_gate clk_out_gate_chk u_chk (
  .pwr_good    (pwr_good),
  .pin_en_cpu  (pin_en_cpu),
  .cpu_en_bit  (ctl_misc[clkgate_pkg::MB_CPU_EN]),
  .cpu_hiz_bit (ctl_misc[clkgate_pkg::MB_CPU_HIZ]),
  .dot_hiz_bit (ctl_misc[clkgate_pkg::MB_DOT_HIZ]),
  .src_cpu     (src_cpu),
  .cpu_t       (cpu_t),
  .cpu_oe      (cpu_oe),
  .src_dot     (src_dot),
  .dot_t       (dot_t),
  .dot_oe      (dot_oe),
  .lane0_src   (se_src[0]),
  .lane0_q     (se_q[0])
);

// File: tb/clk_out_gate_tb.sv
`timescale 1ns/100ps
module clk_out_gate_tb;
  localparam int LANES = 8;
  localparam int SE_N  = LANES + 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic pwr_good = 1'b0;
  logic pin_en_cpu = 1'b1, pin_en_dot = 1'b1, pin_en_lo = 1'b1, pin_en_hi = 1'b1;
  logic [LANES-1:0] ctl_lane_en = '1;
  logic [7:0] ctl_misc = 8'h3F;
  logic src_cpu, src_dot;
  logic [SE_N-1:0] se_src;
  logic cpu_t, cpu_c, cpu_oe, dot_t, dot_c, dot_oe;
  logic [SE_N-1:0] se_q, se_oe;

  assign src_cpu = clk;
  assign src_dot = clk;
  assign se_src  = {SE_N{clk}};

  clk_out_gate u_dut (
    .pwr_good(pwr_good), .pin_en_cpu(pin_en_cpu), .pin_en_dot(pin_en_dot),
    .pin_en_lo(pin_en_lo), .pin_en_hi(pin_en_hi), .ctl_lane_en(ctl_lane_en),
    .ctl_misc(ctl_misc), .src_cpu(src_cpu), .src_dot(src_dot), .se_src(se_src),
    .cpu_t(cpu_t), .cpu_c(cpu_c), .cpu_oe(cpu_oe), .dot_t(dot_t), .dot_c(dot_c),
    .dot_oe(dot_oe), .se_q(se_q), .se_oe(se_oe)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [29:0] observed();
    return {cpu_t, cpu_c, cpu_oe, dot_t, dot_c, dot_oe, se_q, se_oe};
  endfunction

  // pins = {cpu, dot, lo, hi}; ph = source currently high.
  function automatic logic [29:0] expect_vec(input bit pg, input bit ph, input logic [3:0] pins,
                                             input logic [7:0] lane, input logic [7:0] misc);
    logic cr, dr, cq, dq, coe, doe;
    logic [SE_N-1:0] sr;
    cr = pg & pins[3] & misc[1];
    dr = pg & pins[2] & misc[0];
    cq = cr & ph;
    dq = dr & ph;
    coe = pg ? cr : ~misc[7];
    doe = pg ? dr : ~misc[6];
    for (int i = 0; i < LANES; i++)
      sr[i] = pg & lane[i] & ((i < LANES/2) ? pins[1] : pins[0]);
    for (int j = 0; j < 4; j++)
      sr[LANES+j] = pg & misc[2+j];
    return {cq, ~cq, coe, dq, ~dq, doe, sr & {SE_N{ph}}, {SE_N{1'b1}}};
  endfunction

  task automatic compare_all(input logic [29:0] exp, input string extra);
    logic [29:0] act;
    act = observed();
    check({"R4 R5 ", extra}, 32'(act[29:27]), 32'(exp[29:27]));
    check({"R3 R5 ", extra}, 32'(act[26:24]), 32'(exp[26:24]));
    check({"R7 ", extra}, 32'(act[19:12]), 32'(exp[19:12]));
    check({"R8 ", extra}, {16'h0, act[23:20], act[11:0]}, {16'h0, exp[23:20], exp[11:0]});
  endtask

  task automatic apply(input logic [3:0] p, input logic [7:0] lane, input logic [7:0] misc);
    {pin_en_cpu, pin_en_dot, pin_en_lo, pin_en_hi} = p;
    ctl_lane_en = lane;
    ctl_misc = misc;
  endtask

  // Entered and left at a falling edge + 1 ns.
  task automatic sweep_point(input logic [3:0] p, input logic [7:0] lane, input logic [7:0] misc);
    apply(p, lane, misc);
    repeat (3) @(posedge clk);
    #1 compare_all(expect_vec(1, 1, p, lane, misc), "steady high");
    @(negedge clk);
    #1 compare_all(expect_vec(1, 0, p, lane, misc), "R10 steady low");
  endtask

  task automatic pd_cycle(input logic [3:0] p, input logic [7:0] misc);
    sweep_point(p, 8'hFF, misc);
    @(posedge clk);
    #1 pwr_good = 1'b0;
    #0.5 compare_all(expect_vec(0, 1, p, 8'hFF, misc), "R1 async stop");
    @(negedge clk);
    #1 compare_all(expect_vec(0, 0, p, 8'hFF, misc), "R6 pd low phase");
    @(posedge clk);
    #1 compare_all(expect_vec(0, 1, p, 8'hFF, misc), "R1 R6 pd high phase");
    @(negedge clk);
    #1 pwr_good = 1'b1;
    @(posedge clk);
    #1 compare_all(expect_vec(0, 1, p, 8'hFF, misc), "R2 edge1");
    @(posedge clk);
    #1 compare_all(expect_vec(0, 1, p, 8'hFF, misc), "R2 edge2");
    @(posedge clk);
    #1 compare_all(expect_vec(1, 1, p, 8'hFF, misc), "R2 edge3");
    @(negedge clk);
    #1;
  endtask

  task automatic latency_probe(input logic [3:0] p0, input logic [7:0] l0, input logic [7:0] m0,
                               input logic [3:0] p1, input logic [7:0] l1, input logic [7:0] m1);
    sweep_point(p0, l0, m0);
    apply(p1, l1, m1);
    @(posedge clk);
    #1 compare_all(expect_vec(1, 1, p0, l0, m0), "R9 old edge1");
    @(posedge clk);
    #1 compare_all(expect_vec(1, 1, p0, l0, m0), "R9 old edge2");
    @(posedge clk);
    #1 compare_all(expect_vec(1, 1, p1, l1, m1), "R9 new edge3");
    @(negedge clk);
    #1 compare_all(expect_vec(1, 0, p1, l1, m1), "R9 R10 new low");
  endtask

  initial begin : watchdog
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    // Reset state: power-down, pairs driven idle (float selects 0).
    repeat (2) @(negedge clk);
    #1 compare_all(expect_vec(0, 0, 4'hF, 8'hFF, 8'h3F), "R1 R6 reset low");
    @(posedge clk);
    #1 compare_all(expect_vec(0, 1, 4'hF, 8'hFF, 8'h3F), "R1 R6 reset high");
    @(negedge clk);
    #1 pwr_good = 1'b1;
    @(posedge clk);
    #1 compare_all(expect_vec(0, 1, 4'hF, 8'hFF, 8'h3F), "R2 release edge1");
    @(posedge clk);
    #1 compare_all(expect_vec(0, 1, 4'hF, 8'hFF, 8'h3F), "R2 release edge2");
    @(posedge clk);
    #1 compare_all(expect_vec(1, 1, 4'hF, 8'hFF, 8'h3F), "R2 release edge3");
    @(negedge clk);
    #1;

    // Sweep of all pin patterns against 64 control patterns.
    for (int p = 0; p < 16; p++) begin
      for (int m = 0; m < 64; m++) begin
        sweep_point(4'(p), 8'((m * 37) ^ (p * 90)), {2'(p), 6'(m)});
      end
    end

    // Enable change latency, both directions.
    latency_probe(4'hF, 8'hFF, 8'h3F, 4'h7, 8'hDF, 8'h2F);
    latency_probe(4'h7, 8'hDF, 8'h2F, 4'hF, 8'hFF, 8'h3F);
    latency_probe(4'hF, 8'hFF, 8'h3F, 4'hC, 8'h0F, 8'h03);

    // Power-down with each float-select combination, pins on and off.
    for (int h = 0; h < 4; h++) begin
      pd_cycle(4'hF, {2'(h), 6'h3F});
      pd_cycle(4'h0, {2'(h), 6'h3F});
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule